// File: doc/BRIEF.md
# Branch Trace Buffer

This debug unit keeps a history of the program's control-flow changes. Each time the core reports a taken branch while tracing is switched on, the unit stores one entry made of the branch source address and the branch target address. Straight-line code produces no entry, and neither do instructions that a branch jumps over, because the core raises no strobe for them.

Software reaches the unit through a small register bus with three registers: a control word (power, trace enable, an overflow flag and a loop-compression setting), a status word that gives the number of complete entries held, and a data port. Reading the data port drains the history, newest branch first: the target word of an entry comes out before its source word, and the entry count falls only once both words have been taken. The buffer holds a fixed number of entries. When it is full, the oldest entry is overwritten and the overflow flag records that history was lost.

Top module: `flow_trace_buf`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, a data-port read returns 0, and `bus_rdata` is 0.
- R2: A branch strobe is stored only while control bit 0 (power) and control bit 1 (enable) are both 1. In any other state the strobe leaves the count and the contents unchanged.
- R3: The status word (register select 1) gives the number of complete entries held. Each stored branch raises it by one, up to DEPTH (16 by default).
- R4: Data-port reads (register select 2) return entries in last-in, first-out order.
- R5: For each entry, the first data-port read returns the target address and the second read returns the source address.
- R6: The count stays the same after the first word of an entry is read. It drops by one after the second word and reaches 0 once every entry has been drained.
- R7: Writing control value 1 (power on, enable off) stops capture and keeps the contents. Writing any value with bit 0 clear empties the buffer, clears the overflow flag and returns the word toggle to the target word.
- R8: A branch stored while the count equals DEPTH overwrites the oldest entry, leaves the count at DEPTH and sets control bit 2 (overflow). A control write with bit 2 set clears the flag, and a new overflow in the same cycle takes priority over the clear.
- R9: A data-port read while the buffer is empty returns 0 and changes no state.
- R10: When a branch strobe and a data-port read fall in the same cycle, the branch is stored first. The read returns the new entry's target address. Every store returns the word toggle to the target word, so an entry that was half read is restarted later from its target word.
- R11: Control bit 3 (loop compression) is stored and read back as written. It has no effect on capture.
- R12: Register reads return their value on `bus_rdata` in the cycle after the read strobe, and the value holds until the next read. Register select 3 reads as 0. The control word reads as {loop, overflow, enable, power} in bits 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken-branch strobe from the core |
| br_src | input | AW | Address of the branch instruction |
| br_tgt | input | AW | Address the branch goes to |
| bus_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe (control register only) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |

## Verification
The checker tests on every cycle that the count stays within DEPTH and moves only in the allowed ways. Specifically, it checks that a store raises the count, that a first-word read leaves the count alone while a second-word read lowers it, that a strobe arriving while capture is off changes nothing, that a power-down empties the buffer, that an overflow sets the flag, and that an empty read returns zero. Only the bench's scenarios can show the actual addresses that come out and their newest-first, target-then-source order. The same holds for the overwrite of the oldest entry after the buffer wraps, the collision of a read with a store, the restart of a half-read entry, and the read-back of the loop-compression bit.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CB_PWR  = 0;
  localparam int CB_EN   = 1;
  localparam int CB_OVF  = 2;
  localparam int CB_LOOP = 3;
  localparam int CTRL_W  = 4;

  // Control word as software sees it
  function automatic logic [CTRL_W-1:0] ctrl_pack(input logic pwr, input logic en,
                                                  input logic ovf, input logic loop);
    return {loop, ovf, en, pwr};
  endfunction

endpackage

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
  import ftb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              evict_i,
  output logic              pwr_o,
  output logic              en_o,
  output logic              ovf_o,
  output logic              loop_o,
  output logic              clr_o
);

  logic pwr_q, en_q, ovf_q, loop_q;

  // Power-down request empties the store
  assign clr_o = wr_i && !wdata_i[CB_PWR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      if (wr_i) begin
        pwr_q  <= wdata_i[CB_PWR];
        en_q   <= wdata_i[CB_EN];
        loop_q <= wdata_i[CB_LOOP];
      end
      if (clr_o)
        ovf_q <= 1'b0;
      else if (evict_i)
        ovf_q <= 1'b1;
      else if (wr_i && wdata_i[CB_OVF])
        ovf_q <= 1'b0;
    end
  end

  assign pwr_o  = pwr_q;
  assign en_o   = en_q;
  assign ovf_o  = ovf_q;
  assign loop_o = loop_q;

endmodule

// File: rtl/ftb_stack.sv
module ftb_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] tgt_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] cnt_now_o,
  output logic [AW-1:0] word_o,
  output logic          half_o,
  output logic          evict_o,
  output logic          pop_done_o
);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic [AW-1:0] src_mem [DEPTH];
  logic [AW-1:0] tgt_mem [DEPTH];

  logic [PW-1:0] ptr_q, ptr_a, top_idx;
  logic [CW-1:0] cnt_q, cnt_a;
  logic          tog_q, tog_a;
  logic          full, has_entry, take;
  logic [AW-1:0] top_src, top_tgt;

  assign full    = (cnt_q == CW'(DEPTH));
  assign evict_o = cap_i && full;

  // View after the capture of this cycle, which is applied before the read
  assign cnt_a   = cap_i ? (full ? cnt_q : cnt_q + 1'b1) : cnt_q;
  assign ptr_a   = cap_i ? ptr_next(ptr_q) : ptr_q;
  assign tog_a   = cap_i ? 1'b0 : tog_q;
  assign top_idx = ptr_prev(ptr_q);
  assign top_src = cap_i ? src_i : src_mem[top_idx];
  assign top_tgt = cap_i ? tgt_i : tgt_mem[top_idx];

  assign has_entry  = (cnt_a != '0);
  assign take       = pop_i && has_entry;
  assign pop_done_o = take && tog_a;
  assign word_o     = !has_entry ? '0 : (tog_a ? top_src : top_tgt);

  always_ff @(posedge clk) begin
    if (cap_i && !clr_i) begin
      src_mem[ptr_q] <= src_i;
      tgt_mem[ptr_q] <= tgt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      ptr_q <= '0;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (take && tog_a) begin
      ptr_q <= ptr_prev(ptr_a);
      cnt_q <= cnt_a - 1'b1;
      tog_q <= 1'b0;
    end else begin
      ptr_q <= ptr_a;
      cnt_q <= cnt_a;
      tog_q <= take ? 1'b1 : tog_a;
    end
  end

  assign count_o   = cnt_q;
  assign cnt_now_o = cnt_a;
  assign half_o    = tog_q;

endmodule

// File: rtl/ftb_rdport.sv
module ftb_rdport
  import ftb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [AW-1:0]     word_i,
  output logic              pop_o,
  output logic [DW-1:0]     rdata_o
);

  reg_sel_e sel;
  assign sel   = reg_sel_e'(sel_i);
  assign pop_o = rd_i && (sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (sel)
        SEL_CTRL: rdata_o <= DW'(ctrl_i);
        SEL_STAT: rdata_o <= DW'(cnt_i);
        SEL_DATA: rdata_o <= DW'(word_i);
        default:  rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/flow_trace_buf.sv
module flow_trace_buf
  import ftb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_tgt,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);

  // Named internal events, observed by the checker
  logic              cap_fire, pop_fire, pop_done, clr_fire, evict;
  logic              pwr, en, ovf, loop_cmp, half;
  logic              ctrl_wr;
  logic [CW-1:0]     cnt, cnt_now;
  logic [AW-1:0]     word;
  logic [CTRL_W-1:0] ctrl_word;

  wire unused_wbits = ^bus_wdata[DW-1:CTRL_W];

  assign ctrl_wr   = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
  assign cap_fire  = br_valid && pwr && en;
  assign ctrl_word = ctrl_pack(pwr, en, ovf, loop_cmp);

  ftb_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctrl_wr),
    .wdata_i (bus_wdata[CTRL_W-1:0]),
    .evict_i (evict),
    .pwr_o   (pwr),
    .en_o    (en),
    .ovf_o   (ovf),
    .loop_o  (loop_cmp),
    .clr_o   (clr_fire)
  );

  ftb_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_fire),
    .cap_i      (cap_fire),
    .src_i      (br_src),
    .tgt_i      (br_tgt),
    .pop_i      (pop_fire),
    .count_o    (cnt),
    .cnt_now_o  (cnt_now),
    .word_o     (word),
    .half_o     (half),
    .evict_o    (evict),
    .pop_done_o (pop_done)
  );

  ftb_rdport #(.AW(AW), .DW(DW), .CW(CW)) u_rdport (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (bus_rd),
    .sel_i   (bus_sel),
    .ctrl_i  (ctrl_word),
    .cnt_i   (cnt_now),
    .word_i  (word),
    .pop_o   (pop_fire),
    .rdata_o (bus_rdata)
  );

endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic          pwr,
  input logic          en,
  input logic          ovf,
  input logic          cap_fire,
  input logic          pop_fire,
  input logic          pop_done,
  input logic          clr_fire,
  input logic          evict,
  input logic          half,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cnt_now,
  input logic [DW-1:0] bus_rdata
);

  // R3
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3
  a_r3_capture_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !clr_fire && !pop_done && cnt < CW'(DEPTH)) |=> cnt == $past(cnt) + 1'b1);

  // R2
  a_r2_idle_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !(pwr && en) && !pop_fire && !clr_fire) |=> (cnt == $past(cnt)) && (half == $past(half)));

  // R6
  a_r6_first_word_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !cap_fire && !clr_fire && !half && cnt != '0) |=> (cnt == $past(cnt)) && half);

  // R6
  a_r6_second_word_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !cap_fire && !clr_fire && half) |=> (cnt == $past(cnt) - 1'b1) && !half);

  // R7
  a_r7_power_down_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (cnt == '0) && !half && !ovf);

  // R8
  a_r8_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evict && !clr_fire) |=> ovf && (cnt == $past(cnt) || pop_done));

  // R9
  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && cnt_now == '0) |=> (bus_rdata == '0) && (cnt == '0));

  // R10
  a_r10_capture_restarts_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !pop_fire && !clr_fire) |=> !half);

endmodule

bind flow_trace_buf ftb_checker #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_ftb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_valid  (br_valid),
  .pwr       (pwr),
  .en        (en),
  .ovf       (ovf),
  .cap_fire  (cap_fire),
  .pop_fire  (pop_fire),
  .pop_done  (pop_done),
  .clr_fire  (clr_fire),
  .evict     (evict),
  .half      (half),
  .cnt       (cnt),
  .cnt_now   (cnt_now),
  .bus_rdata (bus_rdata)
);

// File: tb/test_flow_trace_buf.sv
module test_flow_trace_buf;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam logic [1:0] S_CTRL = 2'd0, S_STAT = 2'd1, S_DATA = 2'd2, S_NONE = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_valid = 1'b0;
  logic [AW-1:0] br_src = '0, br_tgt = '0;
  logic [1:0]    bus_sel = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  flow_trace_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_flow_trace_buf (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_tgt(br_tgt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    bus_sel = S_CTRL; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic branch(input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    br_valid = 1'b1; br_src = s; br_tgt = t;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic branch_and_read(input logic [31:0] s, input logic [31:0] t,
                                 output logic [31:0] v);
    @(negedge clk);
    br_valid = 1'b1; br_src = s; br_tgt = t;
    bus_sel = S_DATA; bus_rd = 1'b1;
    @(negedge clk);
    br_valid = 1'b0; bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd(S_CTRL, v); chk("R1 control", v, 32'h0);
    rd(S_STAT, v); chk("R1 status", v, 32'h0);
    rd(S_DATA, v); chk("R1 data", v, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    branch(32'h10, 32'h20);
    rd(S_STAT, v); chk("R2 ignored while off", v, 0);
    wr(32'h2);
    branch(32'h10, 32'h20);
    rd(S_STAT, v); chk("R2 ignored without power", v, 0);
    rd(S_NONE, v); chk("R12 unused select reads zero", v, 0);
  endtask

  task automatic t_three_jumps();
    logic [31:0] v;
    wr(32'h3);
    branch(32'h224, 32'h250);
    branch(32'h25a, 32'h234);
    branch(32'h23c, 32'h26c);
    wr(32'h1);
    branch(32'h999, 32'h888);
    rd(S_STAT, v); chk("R3 R7 three entries, stop keeps them", v, 3);
    rd(S_DATA, v); chk("R4 R5 newest target", v, 32'h26c);
    rd(S_STAT, v); chk("R6 count held after first word", v, 3);
    rd(S_DATA, v); chk("R5 newest source", v, 32'h23c);
    rd(S_STAT, v); chk("R6 count drops after second word", v, 2);
    rd(S_DATA, v); chk("R4 second target", v, 32'h234);
    rd(S_STAT, v); chk("R6 count held", v, 2);
    rd(S_DATA, v); chk("R5 second source", v, 32'h25a);
    rd(S_DATA, v); chk("R4 oldest target", v, 32'h250);
    rd(S_STAT, v); chk("R6 count one", v, 1);
    rd(S_DATA, v); chk("R5 oldest source", v, 32'h224);
    rd(S_STAT, v); chk("R6 drained", v, 0);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    rd(S_DATA, v); chk("R9 empty read zero", v, 0);
    rd(S_STAT, v); chk("R9 empty read no change", v, 0);
    rd(S_CTRL, v); chk("R9 control untouched", v, 32'h1);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(32'h3);
    for (int i = 0; i < DEPTH + 2; i++) branch(i * 16, i * 16 + 4);
    rd(S_STAT, v); chk("R8 count saturates", v, DEPTH);
    rd(S_CTRL, v); chk("R8 overflow flag set", v, 32'h7);
    wr(32'h7);
    rd(S_CTRL, v); chk("R8 overflow cleared by write of one", v, 32'h3);
    for (int k = DEPTH + 1; k >= 2; k--) begin
      rd(S_DATA, v); chk("R8 R4 surviving target", v, k * 16 + 4);
      rd(S_DATA, v); chk("R8 R5 surviving source", v, k * 16);
    end
    rd(S_STAT, v); chk("R8 oldest two lost", v, 0);
  endtask

  task automatic t_power_cycle();
    logic [31:0] v;
    wr(32'h3);
    branch(32'h300, 32'h340);
    branch(32'h310, 32'h350);
    rd(S_DATA, v); chk("R5 target before power-down", v, 32'h350);
    wr(32'h0);
    rd(S_STAT, v); chk("R7 power-down empties", v, 0);
    wr(32'h3);
    rd(S_DATA, v); chk("R7 nothing left after power-up", v, 0);
    branch(32'h400, 32'h440);
    rd(S_DATA, v); chk("R7 word toggle reset", v, 32'h440);
    rd(S_DATA, v); chk("R7 source follows", v, 32'h400);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(32'h0); wr(32'h3);
    branch(32'h100, 32'h180);
    rd(S_DATA, v); chk("R5 first entry target", v, 32'h180);
    branch_and_read(32'h200, 32'h280, v); chk("R10 read sees new target", v, 32'h280);
    rd(S_STAT, v); chk("R10 both entries held", v, 2);
    rd(S_DATA, v); chk("R10 new source", v, 32'h200);
    rd(S_DATA, v); chk("R10 half-read entry restarts at target", v, 32'h180);
    rd(S_DATA, v); chk("R10 then its source", v, 32'h100);
    rd(S_STAT, v); chk("R10 drained", v, 0);
  endtask

  task automatic t_loop_bit();
    logic [31:0] v;
    wr(32'hB);
    rd(S_CTRL, v); chk("R11 loop bit reads back", v, 32'hB);
    branch(32'h500, 32'h520);
    rd(S_STAT, v); chk("R11 capture unaffected", v, 1);
    wr(32'h9);
    rd(S_CTRL, v); chk("R11 loop bit with enable off", v, 32'h9);
    branch(32'h600, 32'h620);
    rd(S_STAT, v); chk("R11 R2 no capture when enable off", v, 1);
    @(negedge clk);
    chk("R12 rdata holds without read", bus_rdata, 1);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_three_jumps();
    t_empty();
    t_overflow();
    t_power_cycle();
    t_collision();
    t_loop_bit();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

endmodule